// File: doc/BRIEF.md
# DDR SDRAM Power-Up Command Sequencer

This block produces the command stream that brings a DDR SDRAM out of power-up, once the module configuration is known. A single-cycle start pulse launches the run. The block first waits a power-up deselect interval. It then issues nine commands in a fixed order, one clock-wide strobe per command, and spaces the strobes by programmable cycle counts. These counts meet the device minimums for mode-register settle, precharge recovery and refresh cycle time.

Two selections are captured when the start pulse is accepted. The CAS latency select chooses 2 or 2.5, and it sets the lowest bit of both mode-register commands. The refresh-rate code is the value handed to the external refresh engine. Refresh stays disabled, with its rate forced to zero, for the whole bring-up. It is enabled in the same cycle that the normal-operation command goes out, and the done flag rises at that point.

Top module: `ddr_init_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, cmd_vld_o, done_o and rfr_en_o are 0, rfr_rate_o is 0 and cmd_o holds the NOP code 0101.
- R2: The first strobe appears exactly PWRUP_CYC clock cycles after the rising edge that samples start_i high.
- R3: The strobed codes follow this order: NOP 0101, precharge-all 0100, DLL-enable extended mode set 0110, mode set with DLL reset 001c, precharge-all 0100, auto-refresh 0111, auto-refresh 0111, mode set without DLL reset 000c, normal operation 1111. Here c is the captured CAS bit.
- R4: cl_half_i is captured when start is accepted. Its value is 0 for CAS latency 2 and 1 for 2.5, and later changes to it have no effect on the run.
- R5: cmd_vld_o is high for exactly one clock per command, and cmd_o changes only in a strobe cycle.
- R6: Consecutive strobes are GAP_CYC cycles apart. The exception is the strobe that follows each auto-refresh, which comes GAP_RFC cycles later.
- R7: rfr_en_o is 0 and rfr_rate_o is 0 until the normal-operation strobe. From that cycle on, rfr_en_o is 1 and rfr_rate_o equals the captured refresh code.
- R8: done_o rises in the cycle of the normal-operation strobe and stays high until reset.
- R9: A start pulse that arrives while a run is in progress, or after done_o is set, causes no strobe and does not disturb the run.
- R10: rfr_code_i is captured when start is accepted, and later changes to it do not alter rfr_rate_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start pulse, accepted only when idle and not done |
| cl_half_i | input | 1 | CAS latency select: 0 = 2, 1 = 2.5 |
| rfr_code_i | input | RFR_W | Refresh-rate code applied after bring-up |
| cmd_o | output | 4 | Command code |
| cmd_vld_o | output | 1 | One-clock strobe that qualifies cmd_o |
| rfr_en_o | output | 1 | Refresh engine enable |
| rfr_rate_o | output | RFR_W | Refresh rate, zero while disabled |
| done_o | output | 1 | Sticky bring-up complete flag |

## Verification
The bench records the exact cycle of every strobe against a schedule that it computes from the delay parameters. A design that is off by one in the power-up wait, or that uses the short gap after a refresh, therefore shows up as a strobe in the wrong cycle. Each run toggles the CAS select and the refresh code right after start. A design that decodes them live, rather than capturing them, emits the wrong mode-register bit or a drifting rate. Each run also pulses start in the middle of the sequence and again after completion. A block that restarts would emit a second NOP or jump back in the order. The refresh outputs are checked in every cycle, so an enable that comes one step early or a rate that leaks during bring-up is reported.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [3:0] {
    STEP_NOP,
    STEP_PRE_A,
    STEP_EMRS,
    STEP_MRS_DLLRST,
    STEP_PRE_B,
    STEP_REF_A,
    STEP_REF_B,
    STEP_MRS_RUN,
    STEP_NORMAL
  } step_e;

  localparam logic [3:0] CMD_NOP       = 4'b0101;
  localparam logic [3:0] CMD_PRECHARGE = 4'b0100;
  localparam logic [3:0] CMD_EMRS_DLL  = 4'b0110;
  localparam logic [3:0] CMD_MRS_RST   = 4'b0010; // bit 0 = CAS half
  localparam logic [3:0] CMD_REFRESH   = 4'b0111;
  localparam logic [3:0] CMD_MRS_RUN   = 4'b0000; // bit 0 = CAS half
  localparam logic [3:0] CMD_NORMAL    = 4'b1111;

  function automatic logic [3:0] step_cmd(step_e s, logic cl_half);
    case (s)
      STEP_NOP:        return CMD_NOP;
      STEP_PRE_A:      return CMD_PRECHARGE;
      STEP_EMRS:       return CMD_EMRS_DLL;
      STEP_MRS_DLLRST: return CMD_MRS_RST | {3'b000, cl_half};
      STEP_PRE_B:      return CMD_PRECHARGE;
      STEP_REF_A:      return CMD_REFRESH;
      STEP_REF_B:      return CMD_REFRESH;
      STEP_MRS_RUN:    return CMD_MRS_RUN | {3'b000, cl_half};
      default:         return CMD_NORMAL;
    endcase
  endfunction

  // A refresh must be followed by the longer refresh-cycle gap.
  function automatic logic gap_is_rfc(step_e s);
    return (s == STEP_REF_A) || (s == STEP_REF_B);
  endfunction

endpackage

// File: rtl/ddr_init_timer.sv
module ddr_init_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/ddr_init_steps.sv
module ddr_init_steps
  import ddr_init_pkg::*;
#(
  parameter int CNT_W     = 16,
  parameter int PWRUP_CYC = 50000,
  parameter int GAP_CYC   = 8,
  parameter int GAP_RFC   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             cl_half_i,
  input  logic             expired_i,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic [3:0]       cmd_o,
  output logic             cmd_vld_o,
  output logic             done_o,
  output logic             accept_o,
  output logic             enter_normal_o
);
  logic  busy;
  logic  cl_q;
  step_e step;
  logic  issue;

  assign accept_o       = start_i && !busy && !done_o;
  assign issue          = busy && expired_i;
  assign enter_normal_o = issue && (step == STEP_NORMAL);
  assign load_o         = accept_o || (issue && (step != STEP_NORMAL));

  always_comb begin
    if (accept_o)              load_val_o = CNT_W'(PWRUP_CYC - 1);
    else if (gap_is_rfc(step)) load_val_o = CNT_W'(GAP_RFC - 1);
    else                       load_val_o = CNT_W'(GAP_CYC - 1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      done_o    <= 1'b0;
      cl_q      <= 1'b0;
      step      <= STEP_NOP;
      cmd_o     <= CMD_NOP;
      cmd_vld_o <= 1'b0;
    end else begin
      cmd_vld_o <= issue;
      if (accept_o) begin
        busy <= 1'b1;
        step <= STEP_NOP;
        cl_q <= cl_half_i;
      end
      if (issue) begin
        cmd_o <= step_cmd(step, cl_q);
        if (step == STEP_NORMAL) begin
          busy   <= 1'b0;
          done_o <= 1'b1;
        end else begin
          step <= step_e'(step + 4'd1);
        end
      end
    end
  end
endmodule

// File: rtl/ddr_init_refgate.sv
module ddr_init_refgate #(
  parameter int RFR_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             capture_i,
  input  logic [RFR_W-1:0] code_i,
  input  logic             enable_i,
  output logic             rfr_en_o,
  output logic [RFR_W-1:0] rfr_rate_o
);
  logic [RFR_W-1:0] hold;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold       <= '0;
      rfr_en_o   <= 1'b0;
      rfr_rate_o <= '0;
    end else begin
      if (capture_i) hold <= code_i;
      if (enable_i) begin
        rfr_en_o   <= 1'b1;
        rfr_rate_o <= hold;
      end
    end
  end
endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq #(
  parameter int RFR_W     = 4,
  parameter int PWRUP_CYC = 50000,
  parameter int GAP_CYC   = 8,
  parameter int GAP_RFC   = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             cl_half_i,
  input  logic [RFR_W-1:0] rfr_code_i,
  output logic [3:0]       cmd_o,
  output logic             cmd_vld_o,
  output logic             rfr_en_o,
  output logic [RFR_W-1:0] rfr_rate_o,
  output logic             done_o
);
  localparam int GAP_MAX = (GAP_RFC > GAP_CYC) ? GAP_RFC : GAP_CYC;
  localparam int CNT_MAX = (PWRUP_CYC > GAP_MAX) ? PWRUP_CYC : GAP_MAX;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic             load;
  logic [CNT_W-1:0] load_val;
  logic             expired;
  logic             accept;
  logic             enter_normal;

  ddr_init_timer #(.CNT_W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (load),
    .load_val (load_val),
    .expired  (expired)
  );

  ddr_init_steps #(
    .CNT_W     (CNT_W),
    .PWRUP_CYC (PWRUP_CYC),
    .GAP_CYC   (GAP_CYC),
    .GAP_RFC   (GAP_RFC)
  ) u_steps (
    .clk            (clk),
    .rst            (rst),
    .start_i        (start_i),
    .cl_half_i      (cl_half_i),
    .expired_i      (expired),
    .load_o         (load),
    .load_val_o     (load_val),
    .cmd_o          (cmd_o),
    .cmd_vld_o      (cmd_vld_o),
    .done_o         (done_o),
    .accept_o       (accept),
    .enter_normal_o (enter_normal)
  );

  ddr_init_refgate #(.RFR_W(RFR_W)) u_ref (
    .clk        (clk),
    .rst        (rst),
    .capture_i  (accept),
    .code_i     (rfr_code_i),
    .enable_i   (enter_normal),
    .rfr_en_o   (rfr_en_o),
    .rfr_rate_o (rfr_rate_o)
  );
endmodule

// File: rtl/ddr_init_seq_chk.sv
module ddr_init_seq_chk
  import ddr_init_pkg::*;
#(
  parameter int RFR_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       cmd_o,
  input logic             cmd_vld_o,
  input logic             rfr_en_o,
  input logic [RFR_W-1:0] rfr_rate_o,
  input logic             done_o
);
  logic [7:0] since;
  logic       seen;
  logic [3:0] prev_cmd;

  always_ff @(posedge clk) begin
    if (rst) begin
      since    <= '0;
      seen     <= 1'b0;
      prev_cmd <= CMD_NOP;
    end else if (cmd_vld_o) begin
      since    <= '0;
      seen     <= 1'b1;
      prev_cmd <= cmd_o;
    end else if (since != 8'hFF) begin
      since <= since + 8'd1;
    end
  end

  assert_first_nop_R3: assert property (@(posedge clk) disable iff (rst)
    cmd_vld_o && !seen |-> cmd_o == CMD_NOP);
  assert_strobe_single_R5: assert property (@(posedge clk) disable iff (rst)
    cmd_vld_o |=> !cmd_vld_o);
  assert_cmd_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !cmd_vld_o |-> $stable(cmd_o));
  assert_min_gap_R6: assert property (@(posedge clk) disable iff (rst)
    cmd_vld_o && seen |-> since >= 8'd3);
  assert_rfc_gap_R6: assert property (@(posedge clk) disable iff (rst)
    cmd_vld_o && seen && prev_cmd == CMD_REFRESH |-> since >= 8'd15);
  assert_ref_off_R7: assert property (@(posedge clk) disable iff (rst)
    !rfr_en_o |-> rfr_rate_o == '0);
  assert_ref_after_done_R7: assert property (@(posedge clk) disable iff (rst)
    rfr_en_o |-> done_o);
  assert_done_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |=> done_o);
  assert_done_with_normal_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> cmd_vld_o && cmd_o == CMD_NORMAL);
  assert_quiet_after_done_R9: assert property (@(posedge clk) disable iff (rst)
    done_o && !cmd_vld_o |=> !cmd_vld_o);
endmodule

bind ddr_init_seq ddr_init_seq_chk #(.RFR_W(RFR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_o      (cmd_o),
  .cmd_vld_o  (cmd_vld_o),
  .rfr_en_o   (rfr_en_o),
  .rfr_rate_o (rfr_rate_o),
  .done_o     (done_o)
);

// File: tb/sim_ddr_init_seq.sv
module sim_ddr_init_seq;
  localparam int P  = 40;
  localparam int G  = 8;
  localparam int GR = 16;
  localparam int RW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_i = 1'b0;
  logic          cl_half_i = 1'b0;
  logic [RW-1:0] rfr_code_i = '0;
  logic [3:0]    cmd_o;
  logic          cmd_vld_o;
  logic          rfr_en_o;
  logic [RW-1:0] rfr_rate_o;
  logic          done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  ddr_init_seq #(.RFR_W(RW), .PWRUP_CYC(P), .GAP_CYC(G), .GAP_RFC(GR)) u0 (
    .clk(clk), .rst(rst), .start_i(start_i), .cl_half_i(cl_half_i),
    .rfr_code_i(rfr_code_i), .cmd_o(cmd_o), .cmd_vld_o(cmd_vld_o),
    .rfr_en_o(rfr_en_o), .rfr_rate_o(rfr_rate_o), .done_o(done_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [3:0] exp_code(input int i, input logic cl);
    case (i)
      0: return 4'b0101;
      1: return 4'b0100;
      2: return 4'b0110;
      3: return {3'b001, cl};
      4: return 4'b0100;
      5: return 4'b0111;
      6: return 4'b0111;
      7: return {3'b000, cl};
      default: return 4'b1111;
    endcase
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    start_i = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // R1: outputs at reset and just after it
  task automatic t_reset();
    do_reset();
    chk(cmd_vld_o == 1'b0, "R1 cmd_vld", cmd_vld_o, 0);
    chk(done_o == 1'b0, "R1 done", done_o, 0);
    chk(rfr_en_o == 1'b0 && rfr_rate_o == '0, "R1 refresh", rfr_rate_o, 0);
    chk(cmd_o == 4'b0101, "R1 cmd idle code", cmd_o, 5);
  endtask

  // R2 R3 R4 R5 R6 R7 R8 R9 R10: one full bring-up
  task automatic t_run(input logic cl, input logic [RW-1:0] code);
    int t[9];
    int hit, spurious, refbad, donebad;
    t[0] = P;
    for (int i = 1; i < 9; i++) t[i] = t[i-1] + (((i-1) == 5 || (i-1) == 6) ? GR : G);
    hit = 0; spurious = 0; refbad = 0; donebad = 0;
    do_reset();
    start_i = 1'b1; cl_half_i = cl; rfr_code_i = code;
    @(negedge clk);
    start_i = 1'b0; cl_half_i = ~cl;
    for (int k = 1; k <= t[8] + 4; k++) begin
      int idx;
      bit en_exp;
      @(negedge clk);
      idx = -1;
      for (int i = 0; i < 9; i++) if (t[i] == k) idx = i;
      if (idx >= 0) begin
        chk(cmd_vld_o == 1'b1, "R2/R6 strobe timing", cmd_vld_o, 1);
        chk(cmd_o == exp_code(idx, cl), "R3/R4 command code", cmd_o, exp_code(idx, cl));
        hit++;
      end else if (cmd_vld_o) spurious++;
      en_exp = (k >= t[8]);
      if (rfr_en_o != en_exp || rfr_rate_o != (en_exp ? code : '0)) refbad++;
      if (done_o != en_exp) donebad++;
      start_i = (k == P + 3) || (k == t[3] + 2);
      if (k == 2) rfr_code_i = ~code;
    end
    start_i = 1'b0;
    chk(hit == 9, "R3 command count", hit, 9);
    chk(spurious == 0, "R5/R9 stray strobes", spurious, 0);
    chk(refbad == 0, "R7/R10 refresh outputs", refbad, 0);
    chk(donebad == 0, "R8 done timing", donebad, 0);
  endtask

  // R9 R8: start after completion is ignored, done sticks
  task automatic t_after_done(input logic [RW-1:0] code);
    int strobes = 0;
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < P + 20 * G; k++) begin
      @(negedge clk);
      if (cmd_vld_o) strobes++;
    end
    chk(strobes == 0, "R9 start after done", strobes, 0);
    chk(done_o == 1'b1, "R8 done held", done_o, 1);
    chk(rfr_en_o == 1'b1 && rfr_rate_o == code, "R7 rate held", rfr_rate_o, code);
  endtask

  initial begin
    t_reset();
    t_run(1'b0, 4'd3);
    t_after_done(4'd3);
    t_run(1'b1, 4'd9);
    t_after_done(4'd9);
    t_reset();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule